// File: doc/BRIEF.md
# CAN Error-State Change Interrupt Filter

This block sits beside a CAN controller's error-confinement logic. Each cycle it receives the current error state of the receiver and of the transmitter. It compares each state with the value registered one cycle earlier. A change raises a pending status-change flag only when it passes that direction's programmable sensitivity level. Software can then choose to hear about every change, only about moves into or out of the error range, only about bus-off, or about nothing.

The block holds an 8-bit interrupt-enable register. The register has enables for wake-up, status change, overrun and receive-full, plus the two 2-bit sensitivity fields. The block also reports the receiver and transmitter states to software. These reported fields track the live state, but they freeze while a status-change interrupt is pending, so software reads the state that caused the interrupt. A two-signal initialization handshake controls the register. While initialization is both requested and acknowledged, the register is held at reset except for the sensitivity fields. Writes are taken only while neither signal is high.

Top module: `can_stchg_irq_filter`

## Requirements
- R1: After reset, the enable register reads 0x00, both reported status fields read 00, and every pending flag and interrupt output is 0. Register bit layout: 7 wake-up enable, 6 status-change enable, 5:4 receiver sensitivity, 3:2 transmitter sensitivity, 1 overrun enable, 0 receive-full enable.
- R2: A register write is accepted only when init_req and init_ack are both 0. If either is 1, the write leaves the register unchanged.
- R3: While init_req and init_ack are both 1, bits 7, 6, 1 and 0 of the register are cleared on the next edge, and bits 5:2 keep their values.
- R4: State encoding is 00 OK, 01 warning, 10 error, 11 bus-off. With sensitivity code 00, no change of that direction's state sets the pending flag.
- R5: With sensitivity code 01, a change sets the pending flag only if the old or the new state is bus-off (11).
- R6: With sensitivity code 10, a change sets the pending flag only if the old or the new state is error (10) or bus-off (11).
- R7: With sensitivity code 11, any change of state sets the pending flag.
- R8: While no status-change flag is pending, each reported status field takes the current state input on every edge, so it shows the new state one cycle after a change. While the flag is pending, both reported fields hold their values.
- R9: The status-change flag stays set until stchg_clr is pulsed. If a clear and a qualifying change arrive in the same cycle, the flag stays set.
- R10: err_irq is 1 exactly when the status-change flag is pending and enable bit 6 is 1.
- R11: wake_evt sets the wake flag, and wake_clr clears it. wake_irq is the wake flag ANDed with enable bit 7.
- R12: ovr_irq is ovr_pend ANDed with enable bit 1, and rxf_irq is rxf_pend ANDed with enable bit 0. Both follow their inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_req | input | 1 | Initialization requested |
| init_ack | input | 1 | Initialization acknowledged |
| ien_wr | input | 1 | Write strobe for the enable register |
| ien_wdata | input | 8 | Write data for the enable register |
| ien_rdata | output | 8 | Enable register contents |
| rx_state_in | input | 2 | Current receiver error state |
| tx_state_in | input | 2 | Current transmitter error state |
| rx_status | output | 2 | Reported receiver state |
| tx_status | output | 2 | Reported transmitter state |
| stchg_clr | input | 1 | Write-one clear of the status-change flag |
| wake_evt | input | 1 | Wake-up event pulse |
| wake_clr | input | 1 | Write-one clear of the wake flag |
| ovr_pend | input | 1 | Overrun flag held elsewhere |
| rxf_pend | input | 1 | Receive-full flag held elsewhere |
| stchg_pend | output | 1 | Status-change flag pending |
| wake_pend | output | 1 | Wake flag pending |
| err_irq | output | 1 | Status-change (error) interrupt request |
| wake_irq | output | 1 | Wake-up interrupt request |
| ovr_irq | output | 1 | Overrun interrupt request |
| rxf_irq | output | 1 | Receive-full interrupt request |

## Verification
The bench builds the block with its default configuration: a 2-bit state per direction and two directions. With these values the whole transition space is small enough to cover in full. For each direction, the bench sweeps all four sensitivity codes against every pair of old and new states, 128 cases in total. Each case checks the pending flag, the gated request and the reported field, and the freeze is confirmed whenever the flag sets. It also sweeps every enable and pending combination for the overrun and receive-full requests.

// File: rtl/can_scf_pkg.sv
package can_scf_pkg;

    localparam int unsigned ST_W    = 2;
    localparam int unsigned N_DIR   = 2;
    localparam int unsigned DIR_RX  = 0;
    localparam int unsigned DIR_TX  = 1;

    typedef logic [ST_W-1:0] st_t;

    localparam st_t ST_OK   = 2'd0;
    localparam st_t ST_WARN = 2'd1;
    localparam st_t ST_ERR  = 2'd2;
    localparam st_t ST_BOFF = 2'd3;

    typedef enum logic [1:0] {
        SENS_NONE = 2'd0,
        SENS_BOFF = 2'd1,
        SENS_ERR  = 2'd2,
        SENS_ALL  = 2'd3
    } sens_e;

    // packed order fixes the bit positions software sees
    typedef struct packed {
        logic  wake_en;
        logic  stchg_en;
        sens_e rx_sens;
        sens_e tx_sens;
        logic  ovr_en;
        logic  rxf_en;
    } ien_t;

    localparam int unsigned IEN_W = $bits(ien_t);

endpackage

// File: rtl/can_scf_enreg.sv
module can_scf_enreg
    import can_scf_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init_req,
    input  logic             init_ack,
    input  logic             wr_en,
    input  logic [IEN_W-1:0] wr_data,
    output ien_t             ien
);

    typedef struct packed {
        ien_t ien;
    } enreg_s;

    enreg_s r_d, r_q;

    logic in_init;
    logic wr_open;

    always_comb begin
        in_init = init_req && init_ack;
        wr_open = !init_req && !init_ack;
        r_d     = r_q;
        if (in_init) begin
            // sensitivity fields survive initialization
            r_d.ien.wake_en  = 1'b0;
            r_d.ien.stchg_en = 1'b0;
            r_d.ien.ovr_en   = 1'b0;
            r_d.ien.rxf_en   = 1'b0;
        end else if (wr_en && wr_open) begin
            r_d.ien = ien_t'(wr_data);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign ien = r_q.ien;

endmodule

// File: rtl/can_scf_edge.sv
module can_scf_edge
    import can_scf_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  st_t   cur,
    input  sens_e sens,
    output logic  evt
);

    typedef struct packed {
        st_t prev;
    } edge_s;

    edge_s e_d, e_q;

    logic moved;
    logic touches_boff;
    logic touches_err;

    always_comb begin
        e_d.prev     = cur;
        moved        = (cur != e_q.prev);
        touches_boff = (cur == ST_BOFF) || (e_q.prev == ST_BOFF);
        // error and bus-off share the upper encoding bit
        touches_err  = cur[ST_W-1] || e_q.prev[ST_W-1];
        unique case (sens)
            SENS_NONE: evt = 1'b0;
            SENS_BOFF: evt = moved && touches_boff;
            SENS_ERR:  evt = moved && touches_err;
            SENS_ALL:  evt = moved;
            default:   evt = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_q <= '0;
        end else begin
            e_q <= e_d;
        end
    end

endmodule

// File: rtl/can_scf_flags.sv
module can_scf_flags
    import can_scf_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N_DIR-1:0]      evt,
    input  st_t  [N_DIR-1:0]      cur,
    input  logic                  stchg_clr,
    input  logic                  wake_evt,
    input  logic                  wake_clr,
    output logic                  stchg_pend,
    output logic                  wake_pend,
    output st_t  [N_DIR-1:0]      shown
);

    typedef struct packed {
        logic                 stchg;
        logic                 wake;
        st_t  [N_DIR-1:0]     shown;
    } flag_s;

    flag_s f_d, f_q;

    always_comb begin
        f_d = f_q;
        // a new event outranks a clear in the same cycle
        if (|evt) begin
            f_d.stchg = 1'b1;
        end else if (stchg_clr) begin
            f_d.stchg = 1'b0;
        end
        if (wake_evt) begin
            f_d.wake = 1'b1;
        end else if (wake_clr) begin
            f_d.wake = 1'b0;
        end
        for (int i = 0; i < N_DIR; i++) begin
            if (!f_q.stchg) begin
                f_d.shown[i] = cur[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q <= '0;
        end else begin
            f_q <= f_d;
        end
    end

    assign stchg_pend = f_q.stchg;
    assign wake_pend  = f_q.wake;
    assign shown      = f_q.shown;

endmodule

// File: rtl/can_stchg_irq_filter.sv
module can_stchg_irq_filter
    import can_scf_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init_req,
    input  logic             init_ack,
    input  logic             ien_wr,
    input  logic [IEN_W-1:0] ien_wdata,
    output logic [IEN_W-1:0] ien_rdata,
    input  logic [ST_W-1:0]  rx_state_in,
    input  logic [ST_W-1:0]  tx_state_in,
    output logic [ST_W-1:0]  rx_status,
    output logic [ST_W-1:0]  tx_status,
    input  logic             stchg_clr,
    input  logic             wake_evt,
    input  logic             wake_clr,
    input  logic             ovr_pend,
    input  logic             rxf_pend,
    output logic             stchg_pend,
    output logic             wake_pend,
    output logic             err_irq,
    output logic             wake_irq,
    output logic             ovr_irq,
    output logic             rxf_irq
);

    ien_t              ien;
    st_t   [N_DIR-1:0] cur_arr;
    st_t   [N_DIR-1:0] shown_arr;
    sens_e [N_DIR-1:0] sens_arr;
    logic  [N_DIR-1:0] evt;

    assign cur_arr[DIR_RX]  = rx_state_in;
    assign cur_arr[DIR_TX]  = tx_state_in;
    assign sens_arr[DIR_RX] = ien.rx_sens;
    assign sens_arr[DIR_TX] = ien.tx_sens;

    can_scf_enreg u_enreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .init_req (init_req),
        .init_ack (init_ack),
        .wr_en    (ien_wr),
        .wr_data  (ien_wdata),
        .ien      (ien)
    );

    for (genvar g = 0; g < N_DIR; g++) begin : g_dir
        can_scf_edge u_edge (
            .clk   (clk),
            .rst_n (rst_n),
            .cur   (cur_arr[g]),
            .sens  (sens_arr[g]),
            .evt   (evt[g])
        );
    end

    can_scf_flags u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt        (evt),
        .cur        (cur_arr),
        .stchg_clr  (stchg_clr),
        .wake_evt   (wake_evt),
        .wake_clr   (wake_clr),
        .stchg_pend (stchg_pend),
        .wake_pend  (wake_pend),
        .shown      (shown_arr)
    );

    assign ien_rdata = ien;
    assign rx_status = shown_arr[DIR_RX];
    assign tx_status = shown_arr[DIR_TX];

    assign err_irq  = stchg_pend && ien.stchg_en;
    assign wake_irq = wake_pend  && ien.wake_en;
    assign ovr_irq  = ovr_pend   && ien.ovr_en;
    assign rxf_irq  = rxf_pend   && ien.rxf_en;

endmodule

// File: rtl/can_scf_chk.sv
module can_scf_chk
    import can_scf_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             init_req,
    input logic             init_ack,
    input logic [IEN_W-1:0] ien_rdata,
    input logic [ST_W-1:0]  rx_state_in,
    input logic [ST_W-1:0]  tx_state_in,
    input logic [ST_W-1:0]  rx_status,
    input logic [ST_W-1:0]  tx_status,
    input logic             stchg_clr,
    input logic             wake_evt,
    input logic             stchg_pend,
    input logic             wake_pend,
    input logic             err_irq
);

    assert_wr_blocked_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (init_req != init_ack) |=> $stable(ien_rdata));

    assert_init_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (init_req && init_ack) |=> (ien_rdata[7:6] == 2'b00 && ien_rdata[1:0] == 2'b00
                                   && ien_rdata[5:2] == $past(ien_rdata[5:2])));

    assert_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!stchg_pend && ien_rdata[5:2] == 4'b0000) |=> !stchg_pend);

    assert_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stchg_pend |=> ($stable(rx_status) && $stable(tx_status)));

    assert_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !stchg_pend |=> (rx_status == $past(rx_state_in) && tx_status == $past(tx_state_in)));

    assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (stchg_pend && !stchg_clr) |=> stchg_pend);

    assert_err_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !ien_rdata[6] |-> !err_irq);

    assert_wake_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wake_evt |=> wake_pend);

endmodule

bind can_stchg_irq_filter can_scf_chk u_chk (.*);

// File: tb/sim_can_stchg_irq_filter.sv
module sim_can_stchg_irq_filter;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       init_req, init_ack, ien_wr;
    logic [7:0] ien_wdata, ien_rdata;
    logic [1:0] rx_state_in, tx_state_in, rx_status, tx_status;
    logic       stchg_clr, wake_evt, wake_clr, ovr_pend, rxf_pend;
    logic       stchg_pend, wake_pend, err_irq, wake_irq, ovr_irq, rxf_irq;

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 1'b0;

    always #2 clk = ~clk;

    can_stchg_irq_filter u0 (.*);

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr_ien(input logic [7:0] v);
        ien_wr = 1'b1; ien_wdata = v;
        step();
        ien_wr = 1'b0;
    endtask

    task automatic set_st(input int dir, input int v);
        if (dir == 0) begin rx_state_in = 2'(v); tx_state_in = 2'd0; end
        else          begin tx_state_in = 2'(v); rx_state_in = 2'd0; end
    endtask

    task automatic clear_stchg();
        stchg_clr = 1'b1; step(); stchg_clr = 1'b0; step();
    endtask

    function automatic bit qual(input int code, input int p, input int c);
        if (p == c) return 1'b0;
        case (code)
            0:       return 1'b0;
            1:       return (p == 3) || (c == 3);
            2:       return (p >= 2) || (c >= 2);
            default: return 1'b1;
        endcase
    endfunction

    function automatic string sens_req(input int code);
        case (code)
            0:       return "R4";
            1:       return "R5";
            2:       return "R6";
            default: return "R7";
        endcase
    endfunction

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; init_req = 0; init_ack = 0; ien_wr = 0; ien_wdata = 0;
        rx_state_in = 0; tx_state_in = 0; stchg_clr = 0; wake_evt = 0; wake_clr = 0;
        ovr_pend = 0; rxf_pend = 0;
        step(); step();
        rst_n = 1'b1;
        step();

        // R1 reset state
        chk("R1 ien", int'(ien_rdata), 0);
        chk("R1 rx_status", int'(rx_status), 0);
        chk("R1 tx_status", int'(tx_status), 0);
        chk("R1 flags", int'({stchg_pend, wake_pend}), 0);
        chk("R1 irqs", int'({err_irq, wake_irq, ovr_irq, rxf_irq}), 0);

        // R2 writes blocked by either handshake signal
        wr_ien(8'h5A);
        chk("R2 open write", int'(ien_rdata), 8'h5A);
        init_req = 1'b1; wr_ien(8'hFF);
        chk("R2 req only", int'(ien_rdata), 8'h5A);
        init_req = 1'b0; init_ack = 1'b1; wr_ien(8'h00);
        chk("R2 ack only", int'(ien_rdata), 8'h5A);
        init_ack = 1'b0;

        // R3 initialization holds all but the sensitivity fields
        wr_ien(8'hFF);
        init_req = 1'b1; init_ack = 1'b1; step();
        chk("R3 hold", int'(ien_rdata), 8'h3C);
        wr_ien(8'hC3);
        chk("R3 write in init", int'(ien_rdata), 8'h3C);
        init_req = 1'b0; init_ack = 1'b0; step();
        chk("R3 after init", int'(ien_rdata), 8'h3C);

        // R4..R7, R8, R10 exhaustive transition sweep
        for (int dir = 0; dir < 2; dir++) begin
            for (int code = 0; code < 4; code++) begin
                for (int p = 0; p < 4; p++) begin
                    for (int c = 0; c < 4; c++) begin
                        bit e;
                        e = qual(code, p, c);
                        wr_ien({2'b01, (dir == 0) ? 2'(code) : 2'd0,
                                (dir == 1) ? 2'(code) : 2'd0, 2'b00});
                        set_st(dir, p); step(); step();
                        clear_stchg();
                        set_st(dir, c); step();
                        chk(sens_req(code), int'(stchg_pend), int'(e));
                        chk("R10 err_irq", int'(err_irq), int'(e));
                        chk("R8 follow", int'((dir == 0) ? rx_status : tx_status), c);
                        if (e) begin
                            set_st(dir, (c + 1) % 4); step(); step();
                            chk("R8 freeze", int'((dir == 0) ? rx_status : tx_status), c);
                        end
                        clear_stchg();
                    end
                end
            end
        end

        // R9 clear coinciding with a new event keeps the flag
        wr_ien(8'h3C);
        set_st(0, 0); step(); step(); clear_stchg();
        set_st(0, 1); step();
        chk("R9 set", int'(stchg_pend), 1);
        chk("R10 gated off", int'(err_irq), 0);
        stchg_clr = 1'b1; set_st(0, 2); step(); stchg_clr = 1'b0;
        chk("R9 set wins", int'(stchg_pend), 1);
        stchg_clr = 1'b1; step(); stchg_clr = 1'b0;
        chk("R9 cleared", int'(stchg_pend), 0);
        step();
        chk("R8 resume", int'(rx_status), 2);

        // R11 wake flag
        wr_ien(8'h00);
        wake_evt = 1'b1; step(); wake_evt = 1'b0;
        chk("R11 pend", int'(wake_pend), 1);
        chk("R11 gated", int'(wake_irq), 0);
        wr_ien(8'h80);
        chk("R11 irq", int'(wake_irq), 1);
        wake_clr = 1'b1; step(); wake_clr = 1'b0;
        chk("R11 clear", int'({wake_pend, wake_irq}), 0);

        // R12 overrun and receive-full gating, all combinations
        for (int en = 0; en < 4; en++) begin
            wr_ien(8'(en));
            for (int pd = 0; pd < 4; pd++) begin
                ovr_pend = pd[1]; rxf_pend = pd[0];
                #1;
                chk("R12 ovr", int'(ovr_irq), int'(en[1] & pd[1]));
                chk("R12 rxf", int'(rxf_irq), int'(en[0] & pd[0]));
            end
            step();
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule